// File: doc/BRIEF.md
# Sliding-Window Register File

This block holds a physical bank of registers (64 by default, 32 as a build option) and presents only sixteen of them at a time as logical registers 0 to 15. Registers are grouped into quads of four. A window-base register names the physical quad that appears as logical registers 0-3. Logical quads 1, 2 and 3 follow it in order, wrapping around the end of the physical bank.

Two read ports return data combinationally for any logical index. One write port commits on the clock edge. A rotate command moves the window by a signed quad count. A direct load lets neighbouring control logic, such as call and return sequencing, set the window base outright. The current base is driven out so that logic can see it. All pins are plain control and data pins. Nothing moves as a stream, so there is no valid/ready handshake and the block never applies back-pressure: every write, rotate or load presented in a cycle is taken in that cycle.

Top module: `winreg_file`

## Requirements
- R1: While reset is asserted, and after it is released, the window base reads 0.
- R2: Logical index i maps to physical register 4*((base + i[3:2]) mod Q) + i[1:0], where Q is the quad count (16 for 64 registers, 8 for 32).
- R3: The mapping wraps: with Q=16 and base 15, logical quads 0, 1, 2, 3 map to physical quads 15, 0, 1, 2.
- R4: The two read ports are independent and combinational: each returns the mapped register for its own index in the same cycle, under the current base.
- R5: With write enable high, the data lands on the clock edge in the physical register selected by the base in effect during that cycle, even if a rotate or load changes the base on the same edge.
- R6: A rotate adds a signed 4-bit two's-complement quad count (-8 to +7) to the base, modulo Q. After a rotate by +1, the value formerly read at logical 4 is read at logical 0.
- R7: A base load sets the base to the supplied value on the next edge, and takes priority over a rotate in the same cycle.
- R8: With neither rotate nor load, the base is unchanged. With write enable low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the window base |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | DATA_W | Read data, port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | DATA_W | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical index for the write |
| wr_data | input | DATA_W | Write data |
| rot_en | input | 1 | Rotate the window this cycle |
| rot_amt | input | 4 | Signed quad count for the rotate |
| base_ld | input | 1 | Load the window base directly |
| base_ld_val | input | QB | Value to load into the base |
| base_out | output | QB | Current window base |

## Verification
The mapping is exercised first with directed patterns. A full write sweep at base 15 is read back from base 0 and shows that the wrap lands on the right quads. Rotates by +1 and -1 across the zero boundary show that the sign is handled. Same-cycle write-plus-rotate and load-plus-rotate separate the old mapping from the new one and confirm load priority. After these, a long random mix of writes, rotates, loads and idle cycles is run with random read indices on both ports. It is compared against a bench model of the bank, which catches errors in quad offset, wrap arithmetic and port cross-talk that the directed cases could miss.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  localparam int QUAD_SZ = 4;
  localparam int LOG_IDX_W = 4;
  localparam int ROT_W = 4;
  localparam int N_RPORTS = 2;
endpackage

// File: rtl/winreg_base.sv
module winreg_base
  import winreg_pkg::*;
#(
  parameter int QB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rot_en,
  input  logic [ROT_W-1:0] rot_amt,
  input  logic             ld_en,
  input  logic [QB-1:0]    ld_val,
  output logic [QB-1:0]    base
);
  localparam int EW = QB + ROT_W;

  logic [EW-1:0] sum_ext;
  logic [QB-1:0] base_nxt;

  always_comb begin
    sum_ext = EW'(base) + {{QB{rot_amt[ROT_W-1]}}, rot_amt};
    if (ld_en)       base_nxt = ld_val;
    else if (rot_en) base_nxt = sum_ext[QB-1:0];
    else             base_nxt = base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) base <= '0;
    else        base <= base_nxt;
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> base == $past(ld_val)); // R7
  AST_ROT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_en && !ld_en) |=> (EW'(base) == ((EW'($past(base)) + {{QB{$past(rot_amt[ROT_W-1])}}, $past(rot_amt)}) & EW'((1 << QB) - 1)))); // R6
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_en && !ld_en) |=> $stable(base)); // R8
endmodule

// File: rtl/winreg_map.sv
module winreg_map
  import winreg_pkg::*;
#(
  parameter int QB = 4
) (
  input  logic [QB-1:0]        base,
  input  logic [LOG_IDX_W-1:0] lidx,
  output logic [QB+1:0]        paddr
);
  logic [QB-1:0] pquad;

  always_comb begin
    pquad = base + QB'(lidx[3:2]);
    paddr = {pquad, lidx[1:0]};
  end
endmodule

// File: rtl/winreg_store.sv
module winreg_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && raddr_a == waddr) |=> (raddr_a != $past(waddr)) || (rdata_a == $past(wdata))); // R5
endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import winreg_pkg::*;
#(
  parameter int PHYS_REGS = 64,
  parameter int DATA_W    = 32,
  parameter int QB        = $clog2(PHYS_REGS / QUAD_SZ)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LOG_IDX_W-1:0] rd_a_idx,
  output logic [DATA_W-1:0]    rd_a_data,
  input  logic [LOG_IDX_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0]    rd_b_data,
  input  logic                 wr_en,
  input  logic [LOG_IDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rot_en,
  input  logic [ROT_W-1:0]     rot_amt,
  input  logic                 base_ld,
  input  logic [QB-1:0]        base_ld_val,
  output logic [QB-1:0]        base_out
);
  localparam int AW = QB + 2;
  localparam int NMAP = N_RPORTS + 1;

  logic [QB-1:0]        base;
  logic [LOG_IDX_W-1:0] map_in  [NMAP];
  logic [AW-1:0]        map_out [NMAP];

  assign map_in[0] = rd_a_idx;
  assign map_in[1] = rd_b_idx;
  assign map_in[2] = wr_idx;

  winreg_base #(.QB(QB)) u_base (
    .clk(clk), .rst_n(rst_n), .rot_en(rot_en), .rot_amt(rot_amt),
    .ld_en(base_ld), .ld_val(base_ld_val), .base(base)
  );

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    winreg_map #(.QB(QB)) u_map (
      .base(base), .lidx(map_in[g]), .paddr(map_out[g])
    );
  end

  winreg_store #(.DEPTH(PHYS_REGS), .DATA_W(DATA_W), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(map_out[2]), .wdata(wr_data),
    .raddr_a(map_out[0]), .rdata_a(rd_a_data),
    .raddr_b(map_out[1]), .rdata_b(rd_b_data)
  );

  assign base_out = base;

  AST_RESET_BASE: assert property (@(posedge clk)
    !rst_n |=> base_out == '0); // R1
endmodule

// File: tb/tb_winreg_file.sv
`timescale 1ns/1ps
module tb_winreg_file;
  localparam int NQ = 16;
  localparam int DW = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0, rot_amt = 0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = 0;
  logic wr_en = 0, rot_en = 0, base_ld = 0;
  logic [3:0] base_ld_val = 0, base_out;

  int errors = 0, checks = 0;
  logic [DW-1:0] m_mem [NQ*4];
  bit m_ok [NQ*4];
  int m_base = 0;

  winreg_file dut (.*);

  always #10 clk = ~clk;

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic int phys(int b, int idx);
    return (((b + idx / 4) % NQ) * 4) + (idx % 4);
  endfunction

  function automatic int rot(int b, logic [3:0] a);
    int s = $signed(a);
    return ((b + s) % NQ + NQ) % NQ;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on negedge, commit on posedge, update model
  task automatic step(bit we, int wi, logic [DW-1:0] wd, bit re, logic [3:0] ra, bit ld, int lv);
    int p;
    @(negedge clk);
    wr_en = we; wr_idx = 4'(wi); wr_data = wd;
    rot_en = re; rot_amt = ra; base_ld = ld; base_ld_val = 4'(lv);
    @(posedge clk);
    if (we) begin p = phys(m_base, wi); m_mem[p] = wd; m_ok[p] = 1; end
    if (ld) m_base = lv;
    else if (re) m_base = rot(m_base, ra);
    @(negedge clk);
    wr_en = 0; rot_en = 0; base_ld = 0;
  endtask

  task automatic read_chk(string req, int a, int b);
    int pa, pb;
    rd_a_idx = 4'(a); rd_b_idx = 4'(b);
    #2;
    pa = phys(m_base, a); pb = phys(m_base, b);
    if (m_ok[pa]) chk({req, " portA"}, rd_a_data, m_mem[pa]);
    if (m_ok[pb]) chk({req, " portB"}, rd_b_data, m_mem[pb]);
  endtask

  initial begin
    logic [DW-1:0] v4;
    for (int i = 0; i < NQ*4; i++) m_ok[i] = 0;
    repeat (3) @(posedge clk);
    #1 chk("R1 base during reset", 32'(base_out), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 base after reset", 32'(base_out), 0);

    // R3: fill at base 15, read from base 0
    step(0, 0, 0, 0, 0, 1, 15);
    chk("R7 load base", 32'(base_out), 15);
    for (int i = 0; i < 16; i++) step(1, i, 32'hA000 + i, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 12; i++) begin
      rd_a_idx = 4'(i); #2;
      chk("R3 wrap quad", rd_a_data, 32'hA004 + i);
    end
    // fill all remaining quads
    for (int b = 0; b < NQ; b += 4)
      begin
        step(0, 0, 0, 0, 0, 1, b);
        for (int i = 0; i < 16; i++) step(1, i, 32'hB000 + b*4 + i, 0, 0, 0, 0);
      end
    // R2 direct mapping
    step(0, 0, 0, 0, 0, 1, 5);
    read_chk("R2 map", 7, 13);
    // R6 rotate +1
    rd_a_idx = 4; #2; v4 = rd_a_data;
    step(0, 0, 0, 1, 4'd1, 0, 0);
    rd_a_idx = 0; #2;
    chk("R6 rotate +1 logical4->0", rd_a_data, v4);
    chk("R6 base after +1", 32'(base_out), 6);
    // R6 negative wrap
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 4'hF, 0, 0);
    chk("R6 rotate -1 wrap", 32'(base_out), 15);
    step(0, 0, 0, 1, 4'h8, 0, 0);
    chk("R6 rotate -8", 32'(base_out), 7);
    // R7 load beats rotate
    step(0, 0, 0, 1, 4'd3, 1, 2);
    chk("R7 load priority", 32'(base_out), 2);
    // R5 write with rotate same cycle uses old mapping
    step(1, 1, 32'hC0DE0001, 1, 4'd2, 0, 0);
    chk("R6 base after rotate+write", 32'(base_out), 4);
    step(0, 0, 0, 0, 0, 1, 2);
    rd_a_idx = 1; #2;
    chk("R5 write under old mapping", rd_a_data, 32'hC0DE0001);
    // R8 idle with write disabled
    rd_a_idx = 1; rd_b_idx = 9;
    step(0, 1, 32'hDEAD, 0, 0, 0, 0);
    chk("R8 base held", 32'(base_out), 2);
    read_chk("R8 no write", 1, 9);

    // random mix
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED);
    end
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 9);
      step(op < 5, $urandom_range(0, 15), $urandom, op == 5 || op == 6 || op == 8,
           4'($urandom), op == 7 || op == 8, $urandom_range(0, NQ-1));
      chk("R6/R7/R8 base model", 32'(base_out), 32'(m_base));
      read_chk("R2/R4/R5 random", $urandom_range(0, 15), $urandom_range(0, 15));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule